// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Bit Set and Clear Access

This block owns one parallel port of eight pads. Software reaches it over a small synchronous register bus: an address, a write strobe and write data are sampled on the rising clock edge, and read data follows the address combinationally. Each pin has three configuration bits: one selects GPIO or a primary peripheral function, one gives the direction, and one holds the output value. The block drives the pad output value and output enable, passes pad levels to the peripheral, and brings the pad levels back to software through a two-stage synchronizer.

Single output bits can be raised or lowered without a read-modify-write. A write to the set address ORs ones into the output register. A write to the clear address ANDs the written value into it, so each zero clears a bit. Reading the output register returns the stored value. Reading the set address returns the synchronized pin levels, whatever the direction of each pin.

Register offsets: 0 output data, 1 direction, 2 pin select, 3 pin level / set, 4 clear. All other offsets are unmapped.

Top module: `gpio_port`

## Requirements
- R1: After reset the output data and direction registers are 0x00, and the pin select register equals the parameter SEL_RESET (default 0xF0, where a 1 means primary function).
- R2: A write to offset 0 stores the data. A read of offset 0 returns the stored value whatever the pad levels are. The output register changes only on writes to offsets 0, 3 or 4.
- R3: For a GPIO pin (select bit 0), pad_oe equals its direction bit (1 = output) and pad_out equals its output data bit.
- R4: A write to offset 3 sets each output bit whose written bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 4 clears each output bit whose written bit is 0 and leaves the other bits unchanged. A read of offset 4 returns 0x00.
- R6: A read of offset 3 returns the pad level of every GPIO pin, inputs and outputs alike. The value passes two flops, so it reflects a pad change after two rising edges and not after one.
- R7: For a primary-function pin (select bit 1), pad_out and pad_oe follow per_out and per_oe, its direction and data bits have no effect on the pad, and its bit reads as 0 at offset 3.
- R8: per_in carries the raw pad level on primary-function pins and 0 on GPIO pins.
- R9: A write to offset 1 or 2 stores the direction or select value, and a read of that offset returns it.
- R10: A read of an unmapped offset returns 0x00, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| per_out | input | 8 | Peripheral output values |
| per_oe | input | 8 | Peripheral output enables |
| per_in | output | 8 | Pad levels passed to the peripheral |

## Verification
A register write takes effect on the edge that samples the strobe. Its result shows on bus_rdata, pad_out and pad_oe at once after that edge, so the bench drives on the falling edge and checks one step after the next falling edge. A pad change reaches the offset 3 read after exactly two rising edges: the bench checks after one edge that the old value is still there, then checks after the second edge that the new value has arrived. The peripheral paths and the pad multiplexing are combinational, so the bench checks them in the same half cycle as the stimulus.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned OFS_OUT = 0;
  localparam int unsigned OFS_DIR = 1;
  localparam int unsigned OFS_SEL = 2;
  localparam int unsigned OFS_PIN = 3;
  localparam int unsigned OFS_CLR = 4;

  localparam int unsigned WORD_MAX = 32;
  typedef logic [WORD_MAX-1:0] word_t;

  // raise every bit written as one
  function automatic word_t bits_raise(input word_t cur, input word_t wr);
    return cur | wr;
  endfunction

  // drop every bit written as zero
  function automatic word_t bits_drop(input word_t cur, input word_t wr);
    return cur & wr;
  endfunction

  // per-bit choice: sel=1 takes alt, sel=0 takes base
  function automatic word_t bits_pick(input word_t sel, input word_t base, input word_t alt);
    return (base & ~sel) | (alt & sel);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned AW      = 3,
  parameter logic [W-1:0] SEL_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  pin_lvl,
  output logic [W-1:0]  out_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  sel_q,
  output logic [W-1:0]  rdata,
  output logic          set_hit,
  output logic          clr_hit
);

  logic out_hit, dir_hit, sel_hit;
  logic [W-1:0] out_d;

  assign out_hit = wr_en && (addr == AW'(OFS_OUT));
  assign dir_hit = wr_en && (addr == AW'(OFS_DIR));
  assign sel_hit = wr_en && (addr == AW'(OFS_SEL));
  assign set_hit = wr_en && (addr == AW'(OFS_PIN));
  assign clr_hit = wr_en && (addr == AW'(OFS_CLR));

  always_comb begin
    out_d = out_q;
    if (out_hit)      out_d = wdata;
    else if (set_hit) out_d = W'(bits_raise(word_t'(out_q), word_t'(wdata)));
    else if (clr_hit) out_d = W'(bits_drop(word_t'(out_q), word_t'(wdata)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      sel_q <= SEL_RST;
    end else begin
      out_q <= out_d;
      if (dir_hit) dir_q <= wdata;
      if (sel_hit) sel_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(OFS_OUT))      rdata = out_q;
    else if (addr == AW'(OFS_DIR)) rdata = dir_q;
    else if (addr == AW'(OFS_SEL)) rdata = sel_q;
    else if (addr == AW'(OFS_PIN)) rdata = pin_lvl & ~sel_q;
  end

endmodule

// File: rtl/gpio_padmux.sv
module gpio_padmux #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] sel,
  input  logic [W-1:0] gpio_out,
  input  logic [W-1:0] gpio_oe,
  input  logic [W-1:0] per_out,
  input  logic [W-1:0] per_oe,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] per_in
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_out[i] = sel[i] ? per_out[i] : gpio_out[i];
    assign pad_oe[i]  = sel[i] ? per_oe[i]  : gpio_oe[i];
    assign per_in[i]  = sel[i] & pad_in[i];
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned  W         = 8,
  parameter int unsigned  AW        = 3,
  parameter int unsigned  SYNC_LEN  = 2,
  parameter logic [W-1:0] SEL_RESET = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  input  logic [W-1:0]  per_out,
  input  logic [W-1:0]  per_oe,
  output logic [W-1:0]  per_in
);

  logic [W-1:0] out_q, dir_q, sel_q, sync_q;
  logic         set_hit, clr_hit;

  gpio_sync #(.W(W), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
  );

  gpio_regs #(.W(W), .AW(AW), .SEL_RST(SEL_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr),
    .wdata(bus_wdata), .pin_lvl(sync_q), .out_q(out_q), .dir_q(dir_q),
    .sel_q(sel_q), .rdata(bus_rdata), .set_hit(set_hit), .clr_hit(clr_hit)
  );

  gpio_padmux #(.W(W)) u_mux (
    .sel(sel_q), .gpio_out(out_q), .gpio_oe(dir_q), .per_out(per_out),
    .per_oe(per_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .per_in(per_in)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned  W       = 8,
  parameter int unsigned  AW      = 3,
  parameter logic [W-1:0] SEL_RST = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  wdata,
  input logic [W-1:0]  out_q,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  sel_q,
  input logic [W-1:0]  sync_q,
  input logic [W-1:0]  pad_in,
  input logic [W-1:0]  pad_out,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  per_out,
  input logic [W-1:0]  per_oe,
  input logic          set_hit,
  input logic          clr_hit
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        age <= '0;
    else if (age != 2) age <= age + 2'd1;
  end

  logic out_touch;
  assign out_touch = wr_en && (addr == AW'(OFS_OUT) || addr == AW'(OFS_PIN) || addr == AW'(OFS_CLR));

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> (out_q == '0 && dir_q == '0 && sel_q == SEL_RST)); // R1

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_touch |=> $stable(out_q)); // R2

  AST_GPIO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ dir_q) & ~sel_q) == '0 && ((pad_out ^ out_q) & ~sel_q) == '0); // R3

  AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> (out_q == ($past(out_q) | $past(wdata)))); // R4

  AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (out_q == ($past(out_q) & $past(wdata)))); // R5

  AST_PIN_LAG_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (sync_q == $past(pad_in, 2))); // R6

  AST_PRIMARY_OWNS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ per_oe) & sel_q) == '0 && ((pad_out ^ per_out) & sel_q) == '0); // R7

endmodule

bind gpio_port gpio_port_chk #(.W(W), .AW(AW), .SEL_RST(SEL_RESET)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
  .out_q(out_q), .dir_q(dir_q), .sel_q(sel_q), .sync_q(sync_q), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe),
  .set_hit(set_hit), .clr_hit(clr_hit)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;

  localparam logic [7:0] SEL_DEF = 8'hF0;
  localparam logic [2:0] A_OUT = 3'd0, A_DIR = 3'd1, A_SEL = 3'd2, A_PIN = 3'd3, A_CLR = 3'd4, A_NONE = 3'd7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, per_in;
  logic [7:0] per_out = '0;
  logic [7:0] per_oe = '0;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  gpio_port #(.SEL_RESET(SEL_DEF)) u_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe),
    .per_in(per_in)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // per-bit mux as the bench states it: where s is set take b, else a
  function automatic logic [7:0] choose(input logic [7:0] s, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = s[i] ? b[i] : a[i];
    return r;
  endfunction

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic bus_read_check(input string req, input logic [2:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    bus_read_check("R1 out", A_OUT, 8'h00);
    bus_read_check("R1 dir", A_DIR, 8'h00);
    bus_read_check("R1 sel", A_SEL, SEL_DEF);
    check("R1 pad_oe", pad_oe, 8'h00);
  endtask

  task automatic t_sel_dir;
    bus_write(A_SEL, 8'h00);
    bus_read_check("R9 sel", A_SEL, 8'h00);
    bus_write(A_DIR, 8'h0F);
    bus_read_check("R9 dir", A_DIR, 8'h0F);
  endtask

  task automatic t_out_rw;
    bus_write(A_OUT, 8'hA5);
    pad_in = 8'h00;
    bus_read_check("R2 stored", A_OUT, 8'hA5);
    check("R3 pad_out", pad_out, 8'hA5);
    check("R3 pad_oe", pad_oe, 8'h0F);
  endtask

  task automatic t_set;
    bus_write(A_PIN, 8'h12);
    bus_read_check("R4 set", A_OUT, 8'hB7);
    bus_write(A_PIN, 8'h00);
    bus_read_check("R4 zeros", A_OUT, 8'hB7);
  endtask

  task automatic t_clr;
    bus_write(A_CLR, 8'hF0);
    bus_read_check("R5 clear", A_OUT, 8'hB0);
    bus_write(A_CLR, 8'hFF);
    bus_read_check("R5 ones", A_OUT, 8'hB0);
    bus_read_check("R5 read", A_CLR, 8'h00);
  endtask

  task automatic t_pin;
    bus_addr = A_PIN;
    @(negedge clk);
    pad_in = 8'h3C;
    @(negedge clk); #1;
    check("R6 one edge", bus_rdata, 8'h00);
    @(negedge clk); #1;
    check("R6 two edges", bus_rdata, 8'h3C);
    bus_read_check("R2 pins ignored", A_OUT, 8'hB0);
  endtask

  task automatic t_primary;
    per_out = 8'h55; per_oe = 8'h40;
    bus_write(A_SEL, 8'hC0);
    check("R7 pad_out", pad_out, choose(8'hC0, 8'hB0, 8'h55));
    check("R7 pad_oe", pad_oe, choose(8'hC0, 8'h0F, 8'h40));
    bus_write(A_DIR, 8'hFF);
    check("R7 dir ignored", pad_oe, 8'h7F);
    bus_read_check("R7 pin masked", A_PIN, 8'h3C & 8'h3F);
    check("R8 per_in low", per_in, 8'h00);
    @(negedge clk);
    pad_in = 8'hC3;
    #1;
    check("R8 per_in", per_in, 8'hC0);
    @(negedge clk); @(negedge clk); #1;
    bus_read_check("R7 pin after", A_PIN, 8'h03);
  endtask

  task automatic t_unmapped;
    bus_write(A_NONE, 8'hFF);
    bus_read_check("R10 read", A_NONE, 8'h00);
    bus_read_check("R10 out", A_OUT, 8'hB0);
    bus_read_check("R10 dir", A_DIR, 8'hFF);
    bus_read_check("R10 sel", A_SEL, 8'hC0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset;
    t_sel_dir;
    t_out_rw;
    t_set;
    t_clr;
    t_pin;
    t_primary;
    t_unmapped;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule